// File: doc/BRIEF.md
# Clock-Switch-Immune Microsecond Timestamp

This block keeps a 64-bit microsecond timestamp. The timestamp stays correct while the system clock changes frequency, because time is measured from a fixed reference clock and not from the system clock. In the reference domain, a divider turns the fixed reference into a one-microsecond tick. Each tick toggles a carrier, so the carrier is a square wave at half the tick rate, with 50% duty, and it idles high when stopped. The system clock domain samples the carrier through a synchronizer. Every rising edge and every falling edge advances a fine counter, so the fine counter advances once per microsecond.

The fine counter wraps to zero when it reaches its high limit (30000 by default). A wrap sets two flags: a pending marker and a sticky event flag that software clears by writing one. The pending marker makes a coarse accumulator add its step (30 by default) on the following cycle, and the marker then drops. A read request captures a coherent value, coarse × units-per-step + fine. If a wrap is still pending at that moment, one step is added to the coarse value used in the read, so that the result never falls behind.

Stop freezes counting and parks the carrier high. Start clears the fine counter and the event flag, and resumes counting. The system clock must run at least four times faster than the carrier edge rate.

Top module: `tsc_timestamp`

## Requirements
- R1: After reset, evtFlag is 0, carrierOut is 1 (idle high) and rdValid is 0. A read before any start returns 0.
- R2: While running, carrierOut toggles once every REF_DIV reference clock cycles, giving a 50% duty square wave. While stopped, it settles at 1.
- R3: Every edge of the carrier, rising or falling, advances the fine count by one. The timestamp therefore grows by one per REF_DIV reference cycles, that is, one per microsecond.
- R4: The fine count stays below FINE_LIMIT. On the edge that would reach FINE_LIMIT, it returns to 0 and evtFlag is set to 1.
- R5: Each wrap adds COARSE_STEP to the coarse accumulator. The timestamp equals coarse × UNITS_PER_COARSE + fine, and it stays continuous across a wrap.
- R6: A read captured while a wrap is pending includes the pending step. Back-to-back reads never decrease and never advance by more than 1, even across a wrap.
- R7: evtFlag stays at 1 until a pulse on evtClr clears it on the next clock. When a wrap and a clear occur in the same cycle, the wrap wins.
- R8: stopReq freezes the timestamp. Reads while stopped return the same value.
- R9: startReq clears the fine count and evtFlag and resumes counting. The timestamp then continues from the coarse value, which is a multiple of FINE_LIMIT.
- R10: rdValid is high for exactly the one cycle after a cycle with rdReq high, and rdStamp then holds the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its frequency may change |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| refClk | input | 1 | Fixed-frequency reference clock |
| startReq | input | 1 | Pulse: clear fine count and event flag, start counting |
| stopReq | input | 1 | Pulse: freeze counting, park carrier high (wins over start) |
| evtClr | input | 1 | Write-one-to-clear strobe for evtFlag |
| rdReq | input | 1 | Capture the timestamp this cycle |
| rdValid | output | 1 | Captured timestamp is on rdStamp |
| rdStamp | output | 64 | Captured timestamp in microseconds |
| evtFlag | output | 1 | Sticky wrap event flag |
| carrierOut | output | 1 | Generated square wave, idle high |

## Verification
The assertions check the following on every cycle:
- The fine count stays below its limit.
- A terminal edge produces a zeroed count and a set flag.
- The coarse value moves only by exactly one step.
- A flag clear takes effect unless a wrap collides with it.
- The carrier changes only on a divider tick or while idle.
- Back-to-back captures never decrease.

The bench's scenarios show the rest:
- The absolute rate against an ideal microsecond clock over several wraps.
- The corrected value of a read landing in the cycle of a wrap.
- The measured carrier half period.
- Freezing while stopped.
- The restart value after start clears the fine count.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef struct packed {
    logic countEdge;
    logic clearFine;
    logic service;
    logic capture;
    logic flagClr;
  } tscStrobe_t;
endpackage

// File: rtl/tsc_carrier.sv
module tsc_carrier #(
  parameter int REF_DIV = 40
) (
  input  logic refClk,
  input  logic rst_n,
  input  logic runReq,
  output logic carrierOut
);
  localparam int DIV_W = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);

  logic [1:0]       runSync;
  logic [DIV_W-1:0] divCnt;
  logic             carrierReg;
  logic             runRef;
  logic             tick;

  assign runRef = runSync[1];
  assign tick   = (divCnt == DIV_LAST);

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) runSync <= 2'b00;
    else        runSync <= {runSync[0], runReq};
  end

  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt     <= '0;
      carrierReg <= 1'b1;
    end else if (!runRef) begin
      divCnt     <= '0;
      carrierReg <= 1'b1;
    end else if (tick) begin
      divCnt     <= '0;
      carrierReg <= ~carrierReg;
    end else begin
      divCnt     <= divCnt + 1'b1;
    end
  end

  assign carrierOut = carrierReg;

  // R2: the carrier only moves on a divider tick or when parking idle
  p_carrier_edge_r2: assert property (@(posedge refClk) disable iff (!rst_n)
    (carrierReg != $past(carrierReg)) |-> $past(tick || !runRef));
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       evtClr,
  input  logic       rdReq,
  input  logic       carrierIn,
  output logic       runState,
  output tscStrobe_t strobe
);
  logic [2:0] carSync;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carSync <= 3'b111;
    else        carSync <= {carSync[1:0], carrierIn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= 1'b0;
    else if (stopReq)  run <= 1'b0;
    else if (startReq) run <= 1'b1;
  end

  always_comb begin
    strobe.countEdge = run && (carSync[1] ^ carSync[2]);
    strobe.clearFine = startReq && !stopReq;
    strobe.service   = run;
    strobe.capture   = rdReq;
    strobe.flagClr   = evtClr || (startReq && !stopReq);
  end

  assign runState = run;

  p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |=> !run);
  p_start_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && !stopReq) |=> run);
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int FINE_W           = 16,
  parameter int FINE_LIMIT       = 30000,
  parameter int COARSE_W         = 32,
  parameter int COARSE_STEP      = 30,
  parameter int UNITS_PER_COARSE = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  tscStrobe_t  strobe,
  output logic        rdValid,
  output logic [63:0] rdStamp,
  output logic        evtFlag
);
  localparam logic [FINE_W-1:0]   FINE_LAST = FINE_W'(FINE_LIMIT - 1);
  localparam logic [COARSE_W-1:0] STEPV     = COARSE_W'(COARSE_STEP);
  localparam logic [63:0]         UNITSV    = 64'(UNITS_PER_COARSE);

  logic [FINE_W-1:0]   fine;
  logic [COARSE_W-1:0] coarse;
  logic [COARSE_W-1:0] coarseAdj;
  logic                pending;
  logic                wrapHit;

  assign wrapHit   = strobe.countEdge && !strobe.clearFine && (fine == FINE_LAST);
  assign coarseAdj = coarse + (pending ? STEPV : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fine <= '0;
    else if (strobe.clearFine)   fine <= '0;
    else if (wrapHit)            fine <= '0;
    else if (strobe.countEdge)   fine <= fine + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse  <= '0;
      pending <= 1'b0;
    end else begin
      if (strobe.service && pending) coarse <= coarse + STEPV;
      if (wrapHit)                   pending <= 1'b1;
      else if (strobe.service)       pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              evtFlag <= 1'b0;
    else if (wrapHit)        evtFlag <= 1'b1;
    else if (strobe.flagClr) evtFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdStamp <= '0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.capture)
        rdStamp <= 64'(coarseAdj) * UNITSV + 64'(fine);
    end
  end

  p_fine_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fine < FINE_W'(FINE_LIMIT));
  p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.countEdge && !strobe.clearFine && fine == FINE_LAST) |=> (fine == '0) && evtFlag);
  p_coarse_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse != $past(coarse)) |-> (coarse == $past(coarse) + STEPV));
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.flagClr && !wrapHit) |=> !evtFlag);
  p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> rdValid);
  p_read_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && $past(rdValid) && !$past(strobe.clearFine, 2)) |-> (rdStamp >= $past(rdStamp)));
endmodule

// File: rtl/tsc_timestamp.sv
module tsc_timestamp
  import tsc_pkg::*;
#(
  parameter int REF_DIV          = 40,
  parameter int FINE_W           = 16,
  parameter int FINE_LIMIT       = 30000,
  parameter int COARSE_W         = 32,
  parameter int COARSE_STEP      = 30,
  parameter int UNITS_PER_COARSE = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refClk,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        evtClr,
  input  logic        rdReq,
  output logic        rdValid,
  output logic [63:0] rdStamp,
  output logic        evtFlag,
  output logic        carrierOut
);
  tscStrobe_t strobe;
  logic       runState;

  tsc_carrier #(.REF_DIV(REF_DIV)) i_carrier (
    .refClk(refClk), .rst_n(rst_n), .runReq(runState), .carrierOut(carrierOut)
  );

  tsc_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .stopReq(stopReq),
    .evtClr(evtClr), .rdReq(rdReq), .carrierIn(carrierOut),
    .runState(runState), .strobe(strobe)
  );

  tsc_datapath #(
    .FINE_W(FINE_W), .FINE_LIMIT(FINE_LIMIT), .COARSE_W(COARSE_W),
    .COARSE_STEP(COARSE_STEP), .UNITS_PER_COARSE(UNITS_PER_COARSE)
  ) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rdValid(rdValid), .rdStamp(rdStamp), .evtFlag(evtFlag)
  );
endmodule

// File: tb/test_tsc_timestamp.sv
module test_tsc_timestamp;
  localparam int LIMIT = 30;
  localparam int STEP  = 3;
  localparam int UNITS = 10;
  localparam int DIV   = 50;
  localparam int US_CYC = 100;            // system cycles per microsecond
  localparam int GAP_US [8] = '{7, 13, 25, 2, 31, 40, 9, 55};

  logic clk = 0, refClk = 0, rst_n = 0;
  logic startReq = 0, stopReq = 0, evtClr = 0, rdReq = 0;
  logic rdValid, evtFlag, carrierOut;
  logic [63:0] rdStamp;

  int nChecks = 0, nFails = 0;
  longint tStart = 0, base = 0;
  bit done = 0;

  always #5 clk = ~clk;
  initial begin #3; forever #10 refClk = ~refClk; end

  tsc_timestamp #(.REF_DIV(DIV), .FINE_LIMIT(LIMIT), .COARSE_STEP(STEP),
                  .UNITS_PER_COARSE(UNITS)) i_tsc_timestamp (
    .clk(clk), .rst_n(rst_n), .refClk(refClk), .startReq(startReq),
    .stopReq(stopReq), .evtClr(evtClr), .rdReq(rdReq), .rdValid(rdValid),
    .rdStamp(rdStamp), .evtFlag(evtFlag), .carrierOut(carrierOut)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic readStamp(output longint v, output longint tc, output bit vld);
    rdReq = 1;
    @(posedge clk); tc = longint'($time);
    @(negedge clk); rdReq = 0;
    vld = rdValid; v = longint'(rdStamp);
  endtask

  task automatic pulseStart();
    startReq = 1;
    @(posedge clk); tStart = longint'($time);
    @(negedge clk); startReq = 0;
  endtask

  function automatic longint expectAt(longint tc);
    return base + (tc - tStart) / 1000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    longint v, prev, tc, t1, t2, e;
    bit vld;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(evtFlag == 0, "R1 evtFlag", evtFlag, 0);
    chk(carrierOut == 1, "R1 carrier idle", carrierOut, 1);
    chk(rdValid == 0, "R1 rdValid", rdValid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    readStamp(v, tc, vld);
    chk(v == 0, "R1 stamp before start", v, 0);
    chk(vld == 1, "R10 rdValid after rdReq", vld, 1);
    @(negedge clk);
    chk(rdValid == 0, "R10 rdValid single cycle", rdValid, 0);

    pulseStart();
    // R2: half period of the carrier
    @(carrierOut); t1 = longint'($time);
    @(carrierOut); t2 = longint'($time);
    chk(t2 - t1 == DIV * 20, "R2 half period", t2 - t1, DIV * 20);
    @(negedge clk);

    // table of gaps: each read against the ideal microsecond model (R3, R5)
    prev = 0;
    foreach (GAP_US[i]) begin
      repeat (GAP_US[i] * US_CYC) @(negedge clk);
      readStamp(v, tc, vld);
      e = expectAt(tc);
      chk(v <= e && v >= e - 2, "R3 R5 stamp vs ideal", v, e);
      chk(v >= prev, "R5 monotonic", v, prev);
      prev = v;
    end

    // R4 R6 R7: read in the cycle the wrap becomes visible
    evtClr = 1; @(negedge clk); evtClr = 0;
    chk(evtFlag == 0, "R7 clear", evtFlag, 0);
    for (int k = 0; k < 5000 && !evtFlag; k++) @(negedge clk);
    readStamp(v, tc, vld);
    e = expectAt(tc);
    chk(v % LIMIT == 0, "R4 wrap to zero fine", v % LIMIT, 0);
    chk(v <= e && v >= e - 2, "R6 read at wrap", v, e);
    repeat (20) @(negedge clk);
    chk(evtFlag == 1, "R7 sticky", evtFlag, 1);

    // R6: continuous reads across a wrap
    begin
      bit bad = 0;
      longint bp = 0, bv = 0;
      rdReq = 1;
      @(negedge clk); @(negedge clk);
      prev = longint'(rdStamp);
      for (int k = 0; k < 3500; k++) begin
        @(negedge clk);
        v = longint'(rdStamp);
        if (!bad && (!rdValid || v < prev || v - prev > 1)) begin
          bad = 1; bp = prev; bv = v;
        end
        prev = v;
      end
      rdReq = 0;
      chk(!bad, "R6 back-to-back reads", bv, bp);
    end
    @(negedge clk);

    // R8: stop freezes; R2 idle high
    stopReq = 1; @(negedge clk); stopReq = 0;
    readStamp(v, tc, vld);
    repeat (500) @(negedge clk);
    readStamp(prev, tc, vld);
    chk(prev == v, "R8 frozen", prev, v);
    chk(carrierOut == 1, "R2 idle high when stopped", carrierOut, 1);
    chk(evtFlag == 1, "R7 still set while stopped", evtFlag, 1);

    // R9: start clears fine and the flag
    base = (v / LIMIT) * LIMIT;
    pulseStart();
    chk(evtFlag == 0, "R9 flag cleared", evtFlag, 1'b0);
    readStamp(v, tc, vld);
    chk(v == base, "R9 restart base", v, base);
    repeat (12 * US_CYC) @(negedge clk);
    readStamp(v, tc, vld);
    e = expectAt(tc);
    chk(v <= e && v >= e - 2, "R9 R3 counting after restart", v, e);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule